// File: doc/BRIEF.md
# Digit-serial multiply-accumulate ALU

This block is the arithmetic core of a small big-integer and stream-cipher engine. It owns a wide accumulator and, on a start pulse, applies one operation to it: a 32 x 32 multiply or multiply-accumulate, an add or subtract, a bitwise logic operation, a fixed right rotation of the low word, a one-word right shift, or a load/clear. The low 32 bits of the accumulator are always visible on `result`, and a carry/borrow flag records the outcome of the last add or subtract.

Multiplication is digit-serial. Each clock the unit multiplies the multiplicand by one `DIGIT_W`-bit digit of the multiplier and adds the partial product into the accumulator. The accumulator is rotated right by `DIGIT_W` bits after every digit, so each partial product is always added at bit 0. It is rotated back in the final step, so no separate holding register is needed. The accumulator is 99 bits wide: a 64-bit product, three guard bits for column sums, and one extra word for a second product column.

A conditional add or subtract supports constant-time modular correction. The operation is always issued. When the carry flag is clear, the adder input is forced to zero, so the accumulator passes through unchanged with the same timing. The controlling software therefore never branches on a secret-dependent flag.

Top module: `dsmac_alu`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `result`, `carry` and `done` are zero.
- R2: Op code 11 (multiply) sets the accumulator to `opnd_a * opnd_b`. `done` is high for exactly one cycle, namely the cycle after the NDIG-th rising edge, counting from and including the edge that samples `start`. NDIG = ceil(32 / DIGIT_W). `carry` is unchanged.
- R3: Op code 12 (multiply-accumulate) adds the full 64-bit product into the accumulator modulo 2^99, with carries running into bits 64 to 98. The timing is the same as R2.
- R4: Op code 10 shifts the whole accumulator right by 32 bits, filling with zeros.
- R5: Op code 2 (add) and op code 3 (subtract) add or subtract the zero-extended `opnd_a` over all 99 accumulator bits. `carry` becomes the carry out of bit 31 of the low-word sum (add), or 1 when the low word is less than `opnd_a` (subtract).
- R6: Op codes 4, 5 and 6 replace the low word with low-word AND, OR or XOR `opnd_a`. Bits 32 to 98 and `carry` are unchanged.
- R7: Op codes 7 (conditional add) and 8 (conditional subtract) behave as op codes 2 and 3 when `carry` is 1. When `carry` is 0, the accumulator and `carry` are unchanged. In both cases `done` follows one cycle after the start edge.
- R8: Op code 9 rotates the low word right by an amount selected by `rot_sel`: 0→7, 1→9, 2→13, 3→18, 4→2, 5→30, 6 and 7→0. Bits 32 to 98 and `carry` are unchanged.
- R9: A `start` that arrives while a multiply is in progress is ignored.
- R10: Op code 0 clears the accumulator and `carry`. Op code 1 loads the zero-extended `opnd_a` and keeps `carry`. Op codes 13 to 15 change nothing. Every op other than 11 and 12 raises `done` in the cycle after the start edge.
- R11: `DIGIT_W` is restricted to 2, 4, 8, 12 or 16, and any other value stops elaboration. For 12, the multiplier is zero-padded to three digits (R2 with NDIG = 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | Multiplicand, or the operand for add, subtract, logic and load |
| opnd_b | input | 32 | Multiplier |
| rot_sel | input | 3 | Rotation amount select for op code 9 |
| result | output | 32 | Low word of the accumulator |
| carry | output | 1 | Carry/borrow flag |
| done | output | 1 | Operation complete, one-cycle pulse |

## Verification
The bench goes after the three-digit zero-padded multiplier (DIGIT_W = 12). A design that mishandled the padding, or the restore rotation after the last digit, would return a product with its high bits misplaced. Long runs of all-ones multiply-accumulates push carries into the guard bits, and word shifts then expose them; a design with a window mask one bit short would drop or wrap those carries. The conditional add and subtract are issued with the flag both clear and set; a design that ignored the gate would change the accumulator when it should not. A start issued in the middle of a multiply checks that the design does not restart or clobber the partial product.

// File: rtl/dsmac_pkg.sv
package dsmac_pkg;

   localparam int WORD_W    = 32;
   localparam int ROT_SEL_W = 3;

   typedef enum logic [3:0] {
      OP_CLR  = 4'd0,
      OP_LDA  = 4'd1,
      OP_ADD  = 4'd2,
      OP_SUB  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_CADD = 4'd7,
      OP_CSUB = 4'd8,
      OP_ROR  = 4'd9,
      OP_SHW  = 4'd10,
      OP_MUL  = 4'd11,
      OP_MAC  = 4'd12
   } alu_op_e;

   // right-rotation amount of the low word for each select code
   function automatic int rot_amount(input int sel);
      case (sel)
         0:       return 7;
         1:       return 9;
         2:       return 13;
         3:       return 18;
         4:       return 2;
         5:       return 30;
         default: return 0;
      endcase
   endfunction

   function automatic int digit_count(input int dw);
      return (WORD_W + dw - 1) / dw;
   endfunction

endpackage

// File: rtl/dsmac_digit_step.sv
module dsmac_digit_step
   import dsmac_pkg::*;
#(
   parameter  int DIGIT_W = 4,
   parameter  int GUARD_W = 3,
   localparam int ACC_W   = 3 * WORD_W + GUARD_W,
   localparam int NDIG    = digit_count(DIGIT_W),
   localparam int CNT_W   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
   input  logic [ACC_W-1:0]   acc_in,
   input  logic [WORD_W-1:0]  mcand,
   input  logic [DIGIT_W-1:0] digit,
   input  logic [CNT_W-1:0]   step,
   input  logic               last,
   output logic [ACC_W-1:0]   acc_out
);

   localparam int PROD_W  = WORD_W + DIGIT_W;
   localparam int RESTORE = (NDIG - 1) * DIGIT_W;

   logic [PROD_W-1:0]  prod;
   logic [ACC_W-1:0]   prod_ext;
   logic [ACC_W-1:0]   win_mask;
   logic [ACC_W-1:0]   win_sum;
   logic [ACC_W-1:0]   acc_add;
   logic [2*ACC_W-1:0] dbl;
   int                 shamt;

   assign prod     = {{DIGIT_W{1'b0}}, mcand} * {{WORD_W{1'b0}}, digit};
   assign prod_ext = {{(ACC_W-PROD_W){1'b0}}, prod};

   // in the rotated frame the true top bit of the accumulator sits at
   // ACC_W-1-shamt; carries must stop there instead of wrapping
   assign shamt    = int'(step) * DIGIT_W;
   assign win_mask = {ACC_W{1'b1}} >> shamt;
   assign win_sum  = ((acc_in & win_mask) + prod_ext) & win_mask;
   assign acc_add  = win_sum | (acc_in & ~win_mask);
   assign dbl      = {acc_add, acc_add};

   // rotate right one digit, or on the last digit rotate left back home
   assign acc_out  = last ? dbl[ACC_W-RESTORE +: ACC_W] : dbl[DIGIT_W +: ACC_W];

endmodule

// File: rtl/dsmac_rotor.sv
module dsmac_rotor
   import dsmac_pkg::*;
(
   input  logic [WORD_W-1:0]    word_in,
   input  logic [ROT_SEL_W-1:0] sel,
   output logic [WORD_W-1:0]    word_out
);

   localparam int NSEL = 2 ** ROT_SEL_W;

   logic [2*WORD_W-1:0] dbl;
   logic [WORD_W-1:0]   cand [NSEL];

   assign dbl = {word_in, word_in};

   for (genvar s = 0; s < NSEL; s++) begin : g_amt
      localparam int K = rot_amount(s);
      if (K == 0) begin : g_pass
         assign cand[s] = word_in;
      end else begin : g_rot
         assign cand[s] = dbl[K +: WORD_W];
      end
   end

   assign word_out = cand[sel];

endmodule

// File: rtl/dsmac_wordop.sv
module dsmac_wordop
   import dsmac_pkg::*;
#(
   parameter int ACC_W = 99
) (
   input  logic [3:0]        op,
   input  logic [ACC_W-1:0]  acc,
   input  logic [WORD_W-1:0] opnd,
   input  logic [WORD_W-1:0] rot_word,
   input  logic              cf,
   output logic [ACC_W-1:0]  acc_nx,
   output logic              cf_nx
);

   localparam int HI_W = ACC_W - WORD_W;

   logic              is_cond;
   logic              gate_en;
   logic [WORD_W-1:0] addend;
   logic [ACC_W-1:0]  addend_ext;
   logic [WORD_W:0]   lo_sum;
   logic [WORD_W:0]   lo_dif;
   logic [ACC_W-1:0]  full_sum;
   logic [ACC_W-1:0]  full_dif;

   // conditional ops always run; the adder input is zeroed when the flag is clear
   assign is_cond    = (op == OP_CADD) || (op == OP_CSUB);
   assign gate_en    = !is_cond || cf;
   assign addend     = gate_en ? opnd : '0;
   assign addend_ext = {{HI_W{1'b0}}, addend};
   assign lo_sum     = {1'b0, acc[WORD_W-1:0]} + {1'b0, addend};
   assign lo_dif     = {1'b0, acc[WORD_W-1:0]} - {1'b0, addend};
   assign full_sum   = acc + addend_ext;
   assign full_dif   = acc - addend_ext;

   always_comb begin
      acc_nx = acc;
      cf_nx  = cf;
      case (op)
         OP_CLR: begin
            acc_nx = '0;
            cf_nx  = 1'b0;
         end
         OP_LDA:  acc_nx = {{HI_W{1'b0}}, opnd};
         OP_ADD, OP_CADD: begin
            acc_nx = full_sum;
            cf_nx  = lo_sum[WORD_W];
         end
         OP_SUB, OP_CSUB: begin
            acc_nx = full_dif;
            cf_nx  = lo_dif[WORD_W];
         end
         OP_AND:  acc_nx = {acc[ACC_W-1:WORD_W], acc[WORD_W-1:0] & opnd};
         OP_OR:   acc_nx = {acc[ACC_W-1:WORD_W], acc[WORD_W-1:0] | opnd};
         OP_XOR:  acc_nx = {acc[ACC_W-1:WORD_W], acc[WORD_W-1:0] ^ opnd};
         OP_ROR:  acc_nx = {acc[ACC_W-1:WORD_W], rot_word};
         OP_SHW:  acc_nx = {{WORD_W{1'b0}}, acc[ACC_W-1:WORD_W]};
         default: acc_nx = acc;
      endcase
   end

endmodule

// File: rtl/dsmac_alu.sv
module dsmac_alu
   import dsmac_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int GUARD_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [3:0]           op,
   input  logic [WORD_W-1:0]    opnd_a,
   input  logic [WORD_W-1:0]    opnd_b,
   input  logic [ROT_SEL_W-1:0] rot_sel,
   output logic [WORD_W-1:0]    result,
   output logic                 carry,
   output logic                 done
);

   localparam int ACC_W = 3 * WORD_W + GUARD_W;
   localparam int NDIG  = digit_count(DIGIT_W);
   localparam int CNT_W = (NDIG > 1) ? $clog2(NDIG) : 1;

   // R11 digit size is restricted to the supported set
   if (!(DIGIT_W == 2 || DIGIT_W == 4 || DIGIT_W == 8 ||
         DIGIT_W == 12 || DIGIT_W == 16)) begin : g_bad_digit
      $error("dsmac_alu: DIGIT_W must be 2, 4, 8, 12 or 16");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("dsmac_alu: GUARD_W must be at least 1");
   end

   logic [ACC_W-1:0]   acc_q;
   logic               cf_q;
   logic               done_q;
   logic               busy_q;
   logic [CNT_W-1:0]   step_q;
   logic [WORD_W-1:0]  mcand_q;
   logic [WORD_W-1:0]  mplier_q;

   logic               accept;
   logic               is_mul;
   logic [ACC_W-1:0]   st_acc;
   logic [WORD_W-1:0]  st_mcand;
   logic [DIGIT_W-1:0] st_digit;
   logic [CNT_W-1:0]   st_step;
   logic               st_last;
   logic [ACC_W-1:0]   st_out;
   logic [WORD_W-1:0]  rot_word;
   logic [ACC_W-1:0]   wop_acc;
   logic               wop_cf;

   assign accept = start && !busy_q;
   assign is_mul = (op == OP_MUL) || (op == OP_MAC);

   // first digit comes straight from the ports, later ones from the latches
   always_comb begin
      if (busy_q) begin
         st_acc   = acc_q;
         st_mcand = mcand_q;
         st_digit = mplier_q[DIGIT_W-1:0];
         st_step  = step_q;
         st_last  = (step_q == CNT_W'(NDIG - 1));
      end else begin
         st_acc   = (op == OP_MAC) ? acc_q : '0;
         st_mcand = opnd_a;
         st_digit = opnd_b[DIGIT_W-1:0];
         st_step  = '0;
         st_last  = (NDIG == 1);
      end
   end

   dsmac_digit_step #(
      .DIGIT_W (DIGIT_W),
      .GUARD_W (GUARD_W)
   ) u_step (
      .acc_in  (st_acc),
      .mcand   (st_mcand),
      .digit   (st_digit),
      .step    (st_step),
      .last    (st_last),
      .acc_out (st_out)
   );

   dsmac_rotor u_rot (
      .word_in  (acc_q[WORD_W-1:0]),
      .sel      (rot_sel),
      .word_out (rot_word)
   );

   dsmac_wordop #(
      .ACC_W (ACC_W)
   ) u_wop (
      .op       (op),
      .acc      (acc_q),
      .opnd     (opnd_a),
      .rot_word (rot_word),
      .cf       (cf_q),
      .acc_nx   (wop_acc),
      .cf_nx    (wop_cf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         cf_q     <= 1'b0;
         done_q   <= 1'b0;
         busy_q   <= 1'b0;
         step_q   <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            acc_q    <= st_out;
            step_q   <= step_q + 1'b1;
            mplier_q <= mplier_q >> DIGIT_W;
            if (st_last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (accept && is_mul) begin
            acc_q    <= st_out;
            mcand_q  <= opnd_a;
            mplier_q <= opnd_b >> DIGIT_W;
            step_q   <= CNT_W'(1);
            busy_q   <= !st_last;
            done_q   <= st_last;
         end else if (accept) begin
            acc_q  <= wop_acc;
            cf_q   <= wop_cf;
            done_q <= 1'b1;
         end
      end
   end

   assign result = acc_q[WORD_W-1:0];
   assign carry  = cf_q;
   assign done   = done_q;

endmodule

// File: rtl/dsmac_alu_chk.sv
module dsmac_alu_chk
   import dsmac_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int GUARD_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        op,
   input logic [WORD_W-1:0] opnd_a,
   input logic [WORD_W-1:0] result,
   input logic              carry,
   input logic              done,
   input logic              busy,
   input logic [WORD_W-1:0] acc_mid
);

   localparam int NDIG = digit_count(DIGIT_W);

   logic            acc_ok;
   logic [7:0]      cnt_q;
   logic [WORD_W:0] add_chk;
   logic            is_logic;

   assign acc_ok   = start && !busy;
   assign add_chk  = {1'b0, result} + {1'b0, opnd_a};
   assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);

   always_ff @(posedge clk) begin
      if (!rst_n)                                          cnt_q <= '0;
      else if (cnt_q != 0)                                 cnt_q <= cnt_q - 1'b1;
      else if (acc_ok && (op == OP_MUL || op == OP_MAC))   cnt_q <= 8'(NDIG - 1);
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (!done && !carry && result == '0));

   // R2
   mul_done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == 8'd1) |=> done);

   // R9
   busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R4
   shift_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && op == OP_SHW) |=> (result == $past(acc_mid)));

   // R5
   add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && op == OP_ADD) |=> (carry == $past(add_chk[WORD_W])));

   // R6
   logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && is_logic) |=> $stable(carry));

   // R7
   gated_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && (op == OP_CADD || op == OP_CSUB) && !carry) |=> ($stable(result) && !carry && done));

endmodule

bind dsmac_alu dsmac_alu_chk #(
   .DIGIT_W (DIGIT_W),
   .GUARD_W (GUARD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .opnd_a  (opnd_a),
   .result  (result),
   .carry   (carry),
   .done    (done),
   .busy    (busy_q),
   .acc_mid (acc_q[2*dsmac_pkg::WORD_W-1:dsmac_pkg::WORD_W])
);

// File: tb/tb_dsmac_alu.sv
`timescale 1ns/1ps
module tb_dsmac_alu;

   localparam int DW   = 12;
   localparam int NDIG = (32 + DW - 1) / DW;
   localparam int AW   = 99;

   localparam logic [3:0] C_CLR = 0, C_LDA = 1, C_ADD = 2, C_SUB = 3, C_AND = 4,
                          C_OR = 5, C_XOR = 6, C_CADD = 7, C_CSUB = 8, C_ROR = 9,
                          C_SHW = 10, C_MUL = 11, C_MAC = 12;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0;
   logic [3:0]  op = 0;
   logic [31:0] opnd_a = 0, opnd_b = 0;
   logic [2:0]  rot_sel = 0;
   logic [31:0] result;
   logic        carry, done;

   always #2 clk = ~clk;

   dsmac_alu #(.DIGIT_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .rot_sel(rot_sel), .result(result), .carry(carry), .done(done)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // behavioural reference
   logic [AW-1:0] m_acc, m_pend;
   logic          m_cf, m_done;
   int            m_cnt;
   string         cur_req = "R1", m_req = "R1";

   function automatic int rot_of(input logic [2:0] s);
      case (s)
         0: return 7;  1: return 9;  2: return 13; 3: return 18;
         4: return 2;  5: return 30; default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = '0; m_cf = 0; m_done = 0; m_cnt = 0; m_req = "R1";
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_acc = m_pend; m_done = 1; end
         end else if (start) begin
            m_req = cur_req;
            case (op)
               C_MUL, C_MAC: begin
                  m_pend = ((op == C_MAC) ? m_acc : '0) + (AW'(opnd_a) * AW'(opnd_b));
                  m_cnt  = NDIG - 1;
                  if (m_cnt == 0) begin m_acc = m_pend; m_done = 1; end
               end
               default: begin
                  logic [31:0] lo, a;
                  lo = m_acc[31:0];
                  a  = opnd_a;
                  if ((op == C_CADD || op == C_CSUB) && !m_cf) a = 0;
                  case (op)
                     C_CLR: begin m_acc = '0; m_cf = 0; end
                     C_LDA: m_acc = AW'(opnd_a);
                     C_ADD, C_CADD: begin
                        m_cf  = ((33'(lo) + 33'(a)) >> 32) != 0;
                        m_acc = m_acc + AW'(a);
                     end
                     C_SUB, C_CSUB: begin
                        m_cf  = lo < a;
                        m_acc = m_acc - AW'(a);
                     end
                     C_AND: m_acc[31:0] = lo & a;
                     C_OR:  m_acc[31:0] = lo | a;
                     C_XOR: m_acc[31:0] = lo ^ a;
                     C_ROR: begin
                        int k;
                        k = rot_of(rot_sel);
                        m_acc[31:0] = (k == 0) ? lo : ((lo >> k) | (lo << (32 - k)));
                     end
                     C_SHW: m_acc = m_acc >> 32;
                     default: ;
                  endcase
                  m_done = 1;
               end
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", m_req, what, act, exp);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(done == m_done, "done", AW'(done), AW'(m_done));
         chk(carry == m_cf, "carry", AW'(carry), AW'(m_cf));
         if (m_cnt == 0)
            chk(result == m_acc[31:0], "result", AW'(result), AW'(m_acc[31:0]));
      end
   end

   task automatic do_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [2:0] s, input string req);
      cur_req = req; op = o; opnd_a = a; opnd_b = b; rot_sel = s; start = 1;
      @(negedge clk);
      start = 0;
      while (m_cnt > 0) @(negedge clk);
   endtask

   task automatic summary;
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, checked while reset is still held
      m_req = "R1";
      chk(result == 0 && carry == 0 && done == 0, "reset", AW'(result), 0);
      rst_n = 1;
      @(negedge clk);
      chk(result == 0 && carry == 0 && done == 0, "after reset", AW'(result), 0);

      // R10 load, clear, undefined codes
      do_op(C_LDA, 32'hDEADBEEF, 0, 0, "R10");
      do_op(4'd14, 32'h12345678, 0, 0, "R10");
      do_op(4'd13, 32'h0, 0, 0, "R10");
      do_op(C_CLR, 32'h0, 0, 0, "R10");

      // R5 add carry, subtract borrow
      do_op(C_LDA, 32'hDEADBEEF, 0, 0, "R5");
      do_op(C_ADD, 32'h30000000, 0, 0, "R5");
      do_op(C_SHW, 0, 0, 0, "R4");
      do_op(C_LDA, 32'd10, 0, 0, "R5");
      do_op(C_SUB, 32'd3, 0, 0, "R5");

      // R7 gated correction with flag clear, then active with flag set
      do_op(C_CADD, 32'd100, 0, 0, "R7");
      do_op(C_CSUB, 32'd100, 0, 0, "R7");
      do_op(C_SUB, 32'd20, 0, 0, "R5");
      do_op(C_CSUB, 32'd1, 0, 0, "R7");
      do_op(C_CADD, 32'd21, 0, 0, "R7");

      // R6 logic ops keep upper bits: make them all ones first
      do_op(C_LDA, 32'd0, 0, 0, "R6");
      do_op(C_SUB, 32'd1, 0, 0, "R6");
      do_op(C_AND, 32'hFF00FF00, 0, 0, "R6");
      do_op(C_OR, 32'h0000000F, 0, 0, "R6");
      do_op(C_XOR, 32'hFFFFFFFF, 0, 0, "R6");
      do_op(C_SHW, 0, 0, 0, "R6");

      // R8 every rotate select
      for (int s = 0; s < 8; s++) begin
         do_op(C_LDA, 32'h80000001 ^ (32'h1 << s), 0, 0, "R8");
         do_op(C_ROR, 0, 0, 3'(s), "R8");
      end

      // R2 R11 multiply patterns with the padded three-digit multiplier
      do_op(C_MUL, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R2 R11");
      do_op(C_SHW, 0, 0, 0, "R4");
      do_op(C_MUL, 32'h12345678, 32'h9ABCDEF0, 0, "R2 R11");
      do_op(C_SHW, 0, 0, 0, "R4");
      do_op(C_MUL, 32'h0, 32'hCAFEF00D, 0, "R2");
      do_op(C_MUL, 32'hA5A5A5A5, 32'h1, 0, "R2");
      do_op(C_MUL, 32'h80000000, 32'h3, 0, "R2");
      do_op(C_SHW, 0, 0, 0, "R4");

      // R3 accumulate into guard bits
      do_op(C_CLR, 0, 0, 0, "R3");
      for (int i = 0; i < 10; i++)
         do_op(C_MAC, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R3");
      do_op(C_SHW, 0, 0, 0, "R3");
      do_op(C_SHW, 0, 0, 0, "R3");
      do_op(C_LDA, 32'h00000007, 0, 0, "R3");
      do_op(C_MAC, 32'hF0000001, 32'h0FFFFFFF, 0, "R3");
      do_op(C_SHW, 0, 0, 0, "R3");

      // R9 start during a multiply is ignored
      cur_req = "R9"; op = C_MUL; opnd_a = 32'h31415926; opnd_b = 32'h27182818; start = 1;
      @(negedge clk);
      op = C_CLR; opnd_a = 0;
      @(negedge clk);
      start = 0;
      while (m_cnt > 0) @(negedge clk);
      do_op(C_SHW, 0, 0, 0, "R9");

      repeat (3) @(negedge clk);
      summary();
   end

endmodule